// File: doc/BRIEF.md
# Flagless Two-Source Integer Execution Unit

This unit is the integer execution slice of a processor whose instructions name at most two source registers and which keeps no condition or carry flags. Each accepted operation takes an opcode and two operand words and produces one result word, registered, one cycle later. Besides plain addition and bitwise logic, the unit returns the carry-out of an addition as an ordinary 0/1 register value. It also returns both halves of an unsigned product through separate opcodes. Software therefore builds multi-word (bignum) addition by pairing each add with a carry-out op on the same operands. Carries from two steps are merged with OR.

Carry information exists only in the result word. No operation reads or leaves behind hidden state, so the result of an operation depends only on its opcode and its two operands.

Top module: `alu2_exec`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following cycle shows `out_valid` = 0 and `out_result` = 0.
- R2: `out_valid` at each edge equals `in_valid` sampled at the previous edge (one cycle latency for every opcode).
- R3: Opcode 0 (ADD) yields the low W bits of a+b; the carry is dropped.
- R4: Opcode 1 (CARRY) yields the carry-out of the unsigned sum a+b as 0 or 1 in bit 0; bits W-1..1 are zero.
- R5: Opcode 2 (MULHI) yields bits 2W-1..W of the unsigned 2W-bit product a*b.
- R6: Opcode 3 (MULLO) yields bits W-1..0 of the unsigned product a*b.
- R7: Opcodes 4 (OR), 5 (AND) and 6 (XOR) yield the bitwise function of a and b.
- R8: Opcode 7 is undefined and yields a zero result with `out_valid` still set.
- R9: When `in_valid` is low, `out_result` keeps its previous value and the operand and opcode inputs have no effect.
- R10: No state is carried between operations: a result depends only on the opcode and operands of its own operation, so ADD after an overflowing operation gets no carry-in and CARRY of non-overflowing operands is 0.
- R11: The sequence ADD, CARRY, ADD-with-carry, CARRY, OR over W-bit words reproduces the exact multi-word sum and final carry, including a word where the second partial carry is the one that fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 3 | Opcode (0 ADD, 1 CARRY, 2 MULHI, 3 MULLO, 4 OR, 5 AND, 6 XOR, 7 undefined) |
| in_a | input | W | First source operand |
| in_b | input | W | Second source operand |
| out_valid | output | 1 | Result register holds a new result |
| out_result | output | W | Registered result word |

## Verification
The carry opcode is driven at its edges: all-ones plus one, the largest sum that just fits, and the top bit set in both operands. An adder that took its carry from the wrong bit or from a truncated sum would show 0 where 1 is due. Back-to-back sequences with an overflow followed by a small add expose any hidden carry state, which would add a stray 1. Multiply-high is checked with all-ones operands and with asymmetric halves, which catch a cross-term that is shifted or dropped. A multi-word chain in which only the second partial carry fires confirms that a design forwarding only the operand carry would lose a word of carry.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_ADD   = 3'd0,
    OPC_CARRY = 3'd1,
    OPC_MULHI = 3'd2,
    OPC_MULLO = 3'd3,
    OPC_OR    = 3'd4,
    OPC_AND   = 3'd5,
    OPC_XOR   = 3'd6,
    OPC_RSVD  = 3'd7
  } alu2_op_e;
endpackage

// File: rtl/alu2_sum.sv
// Adder producing the low word and the carry-out from the same operands.
module alu2_sum #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int SW = W + 1;

  logic [SW-1:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[W-1:0];
    cout = wide[W];
  end
endmodule

// File: rtl/alu2_mul.sv
// Unsigned full product. SPLIT selects a four-partial-product form built
// from half-width multipliers instead of one wide multiply.
module alu2_mul #(
  parameter int W     = 32,
  parameter bit SPLIT = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;
  localparam int H  = W / 2;
  localparam int L  = W - H;

  logic [PW-1:0] prod;

  generate
    if (SPLIT) begin : g_split
      logic [W-1:0]  ah, al, bh, bl;
      logic [W-1:0]  m_hh, m_hl, m_lh, m_ll;
      logic [PW-1:0] e_hh, e_hl, e_lh, e_ll;

      always_comb begin
        ah   = {{L{1'b0}}, a[W-1:L]};
        al   = {{H{1'b0}}, a[L-1:0]};
        bh   = {{L{1'b0}}, b[W-1:L]};
        bl   = {{H{1'b0}}, b[L-1:0]};
        m_hh = ah * bh;
        m_hl = ah * bl;
        m_lh = al * bh;
        m_ll = al * bl;
        e_hh = {{W{1'b0}}, m_hh} << (2 * L);
        e_hl = {{W{1'b0}}, m_hl} << L;
        e_lh = {{W{1'b0}}, m_lh} << L;
        e_ll = {{W{1'b0}}, m_ll};
        prod = e_hh + e_hl + e_lh + e_ll;
      end
    end else begin : g_direct
      always_comb begin
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      end
    end
  endgenerate

  assign hi = prod[PW-1:W];
  assign lo = prod[W-1:0];
endmodule

// File: rtl/alu2_logic.sv
// Bitwise unit; selects among OR, AND and XOR.
module alu2_logic
  import alu2_pkg::*;
#(
  parameter int W = 32
) (
  input  alu2_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OPC_OR:  y = a | b;
      OPC_AND: y = a & b;
      OPC_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu2_exec.sv
// Two-source execution unit with registered result and no flag state.
module alu2_exec
  import alu2_pkg::*;
#(
  parameter int W         = 32,
  parameter bit MUL_SPLIT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  output logic            out_valid,
  output logic [W-1:0]    out_result
);
  alu2_op_e     op;
  logic [W-1:0] sum_w, mul_hi, mul_lo, bit_y, nxt;
  logic         sum_c;

  assign op = alu2_op_e'(in_op);

  alu2_sum #(.W(W)) u_sum (
    .a(in_a), .b(in_b), .sum(sum_w), .cout(sum_c)
  );

  alu2_mul #(.W(W), .SPLIT(MUL_SPLIT)) u_mul (
    .a(in_a), .b(in_b), .hi(mul_hi), .lo(mul_lo)
  );

  alu2_logic #(.W(W)) u_logic (
    .op(op), .a(in_a), .b(in_b), .y(bit_y)
  );

  always_comb begin
    case (op)
      OPC_ADD:                  nxt = sum_w;
      OPC_CARRY:                nxt = {{(W-1){1'b0}}, sum_c};
      OPC_MULHI:                nxt = mul_hi;
      OPC_MULLO:                nxt = mul_lo;
      OPC_OR, OPC_AND, OPC_XOR: nxt = bit_y;
      default:                  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= nxt;
    end
  end

  // R1: reset clears the result register
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  // R2: valid follows input valid by one cycle
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4: carry result occupies bit 0 only
  p_carry_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd1) |=> (out_result[W-1:1] == '0));

  // R8: undefined opcode returns zero
  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd7) |=> (out_result == '0));

  // R9: idle cycles leave the result untouched
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
endmodule

// File: tb/tb_alu2_exec.sv
module tb_alu2_exec;
  localparam int  W      = 32;
  localparam time CLK_T  = 10ns;
  localparam int  NWORD  = 4;
  localparam int  WDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_T / 2) clk = ~clk;

  alu2_exec #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Present one operation, return the registered result one cycle later.
  task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] res, output logic vld);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    res = out_result; vld = out_valid;
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] r; logic v;
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", {32'd0, out_result}, 64'd0);
    @(negedge clk); rst = 1'b0;
    run_op(3'd6, 32'hdead_beef, 32'h0, r, v);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run valid", {63'd0, out_valid}, 64'd0);
    check("R1 mid-run result", {32'd0, out_result}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_valid();
    logic [W-1:0] r; logic v;
    run_op(3'd0, 32'd1, 32'd2, r, v);
    check("R2 valid one cycle after", {63'd0, v}, 64'd1);
    @(negedge clk);
    check("R2 valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_add_carry();
    logic [W-1:0] r; logic v;
    logic [W-1:0] av [4] = '{32'hffff_ffff, 32'hffff_fffe, 32'h8000_0000, 32'h1234_5678};
    logic [W-1:0] bv [4] = '{32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 32'h0fed_cba9};
    for (int i = 0; i < 4; i++) begin
      logic [63:0] ref_s;
      ref_s = {32'd0, av[i]} + {32'd0, bv[i]};
      run_op(3'd0, av[i], bv[i], r, v);
      check("R3 add low word", {32'd0, r}, {32'd0, ref_s[31:0]});
      run_op(3'd1, av[i], bv[i], r, v);
      check("R4 carry value", {32'd0, r}, {63'd0, ref_s[32]});
    end
  endtask

  task automatic t_mul();
    logic [W-1:0] r; logic v;
    logic [W-1:0] av [3] = '{32'hffff_ffff, 32'h0001_0000, 32'hc0de_1234};
    logic [W-1:0] bv [3] = '{32'hffff_ffff, 32'h0000_ffff, 32'h00ab_8765};
    for (int i = 0; i < 3; i++) begin
      logic [63:0] p;
      p = {32'd0, av[i]} * {32'd0, bv[i]};
      run_op(3'd2, av[i], bv[i], r, v);
      check("R5 mul high", {32'd0, r}, {32'd0, p[63:32]});
      run_op(3'd3, av[i], bv[i], r, v);
      check("R6 mul low", {32'd0, r}, {32'd0, p[31:0]});
    end
  endtask

  task automatic t_logic();
    logic [W-1:0] r; logic v;
    logic [W-1:0] a = 32'hf0f0_1234;
    logic [W-1:0] b = 32'h0ff0_4321;
    run_op(3'd4, a, b, r, v); check("R7 or",  {32'd0, r}, {32'd0, a | b});
    run_op(3'd5, a, b, r, v); check("R7 and", {32'd0, r}, {32'd0, a & b});
    run_op(3'd6, a, b, r, v); check("R7 xor", {32'd0, r}, {32'd0, a ^ b});
  endtask

  task automatic t_undef();
    logic [W-1:0] r; logic v;
    run_op(3'd7, 32'hffff_ffff, 32'h1234_5678, r, v);
    check("R8 undefined zero", {32'd0, r}, 64'd0);
    check("R8 undefined valid", {63'd0, v}, 64'd1);
  endtask

  task automatic t_idle();
    logic [W-1:0] r; logic v;
    run_op(3'd4, 32'h0000_00a5, 32'h0000_5a00, r, v);
    in_op = 3'd5; in_a = 32'h0; in_b = 32'h0;
    @(negedge clk);
    @(negedge clk);
    check("R9 idle holds result", {32'd0, out_result}, 64'h5aa5);
    check("R9 idle no valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stateless();
    logic [W-1:0] r; logic v;
    run_op(3'd0, 32'hffff_ffff, 32'hffff_ffff, r, v);
    run_op(3'd0, 32'd5, 32'd6, r, v);
    check("R10 add after overflow", {32'd0, r}, 64'd11);
    run_op(3'd1, 32'hffff_ffff, 32'd1, r, v);
    run_op(3'd1, 32'd1, 32'd1, r, v);
    check("R10 carry after carry", {32'd0, r}, 64'd0);
  endtask

  task automatic bignum(input logic [NWORD*W-1:0] u, input logic [NWORD*W-1:0] v, input string tag);
    logic [NWORD*W:0] ref_s, got;
    logic [W-1:0] cy, s, c1, c2, rw, uw, vw;
    logic vd;
    ref_s = {1'b0, u} + {1'b0, v};
    cy = '0;
    got = '0;
    for (int k = 0; k < NWORD; k++) begin
      uw = u[k*W +: W]; vw = v[k*W +: W];
      run_op(3'd0, uw, vw, s, vd);
      run_op(3'd1, uw, vw, c1, vd);
      run_op(3'd0, s, cy, rw, vd);
      run_op(3'd1, s, cy, c2, vd);
      run_op(3'd4, c1, c2, cy, vd);
      got[k*W +: W] = rw;
    end
    got[NWORD*W] = cy[0];
    checks++;
    if (got !== ref_s) begin
      fails++;
      $display("FAIL R11 %s: got %h expected %h", tag, got, ref_s);
    end
    check("R11 carry word upper bits", {32'd0, cy & 32'hffff_fffe}, 64'd0);
  endtask

  task automatic t_bignum();
    logic [NWORD*W-1:0] u, v;
    for (int n = 0; n < 3; n++) begin
      u = {$urandom, $urandom, $urandom, $urandom};
      v = {$urandom, $urandom, $urandom, $urandom};
      bignum(u, v, "random");
    end
    bignum({NWORD*W{1'b1}}, {{(NWORD*W-1){1'b0}}, 1'b1}, "full ripple");
    // word0 overflows via operands; word1 sums to all ones so only the
    // carry-in step overflows
    u = {32'h0000_0003, 32'h0000_0000, 32'h8000_0000, 32'hffff_ffff};
    v = {32'h0000_0004, 32'h0000_0000, 32'h7fff_ffff, 32'h0000_0001};
    bignum(u, v, "second partial carry");
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_valid();
    t_add_carry();
    t_mul();
    t_logic();
    t_undef();
    t_idle();
    t_stateless();
    t_bignum();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule